// File: doc/BRIEF.md
# Iterative Integer Divider

This block divides a 64-bit dividend by a 64-bit divisor over many clock cycles and returns either the quotient or the remainder. One 3-bit opcode selects the form: signed or unsigned, word or doubleword, and quotient or remainder. The arithmetic runs on magnitudes with a restoring shift-and-subtract loop that produces one quotient bit per cycle. Signs are applied after the loop ends.

Some operand pairs have no defined result, and some would overflow. Before the loop starts, the block replaces the divisor in those cases. A zero divisor, in any form, becomes 1. In the signed doubleword form, a most-negative dividend divided by -1 also gets a divisor of 1. Because of these rules, no form ever overflows and every result is defined.

A caller pulses `start_i` while the block is idle and then waits for `done_o`. The result stays on `result_o` until the next operation finishes.

Top module: `div_iter`

## Requirements
- R1: The opcode bits are {word, unsigned, remainder}, with the MSB first: bit 2 set means a word form, bit 1 set means unsigned, and bit 0 set selects the remainder instead of the quotient. The unsigned doubleword forms (opcodes 010 and 011) return the full 64-bit unsigned quotient and remainder.
- R2: The signed doubleword forms (opcodes 000 and 001) truncate the quotient toward zero. A non-zero remainder has the sign of the dividend.
- R3: In the signed doubleword forms, a dividend of 0x8000000000000000 with a divisor of all ones gives quotient 0x8000000000000000 and remainder 0.
- R4: A divisor that is zero after operand extension is replaced by 1. The quotient then equals the extended dividend, shaped by the word rule where that rule applies, and the remainder is 0.
- R5: The signed word forms (opcodes 100 and 101) sign-extend both operands from bit 31 and ignore bits 63..32. They return the low 32 bits of the result sign-extended from bit 31.
- R6: The unsigned word forms (opcodes 110 and 111) zero-extend both operands from bit 31 and ignore bits 63..32. They return the low 32 bits of the result sign-extended from bit 31.
- R7: `start_i` is accepted only while `busy_o` is low, and `busy_o` goes high on the next cycle. `busy_o` then stays high until the cycle in which `done_o` pulses high for exactly one cycle. `done_o` rises XLEN+1 cycles after the accepting edge, and `busy_o` falls in that same cycle.
- R8: A `start_i` pulse while `busy_o` is high is ignored. It does not change the running result, does not shift its completion time, and does not queue a further operation.
- R9: While `rst_n` is low, `busy_o`, `done_o` and `result_o` are 0. This holds even if reset arrives in the middle of an operation.
- R10: `result_o` changes only in the cycle in which `done_o` is high, and it holds its value between completions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin an operation; only takes effect while idle |
| op_i | input | 3 | Operation select {word, unsigned, remainder} |
| dividend_i | input | 64 | Dividend, sampled on the accepting edge |
| divisor_i | input | 64 | Divisor, sampled on the accepting edge |
| busy_o | output | 1 | High while an operation is running |
| done_o | output | 1 | One-cycle pulse when the result becomes valid |
| result_o | output | 64 | Selected quotient or remainder |

## Verification
The bench builds the divider with its default parameters: a 64-bit operand width and a 32-bit word width. These reach the real edge values: the most-negative doubleword, the most-negative word divided by -1, and word operands whose upper halves hold junk. Because the loop runs for the full 64 cycles, the bench can also measure exact completion latency. It places a second start request in the middle of a run and sees that the request is dropped, and it applies reset in the middle of an operation.

// File: rtl/div_iter_pkg.sv
package div_iter_pkg;

  // Opcode layout, MSB first: word form, unsigned, remainder select
  typedef struct packed {
    logic word;
    logic uns;
    logic rem;
  } div_op_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } div_state_e;

endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep
  import div_iter_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  div_op_t             op_i,
  input  logic [XLEN-1:0]     dividend_i,
  input  logic [XLEN-1:0]     divisor_i,
  output logic [XLEN-1:0]     mag_dvd_o,
  output logic [XLEN-1:0]     mag_dvs_o,
  output logic                neg_quo_o,
  output logic                neg_rem_o
);

  logic [XLEN-1:0] sx_a, sx_b, zx_a, zx_b;
  logic [XLEN-1:0] ext_a, ext_b;
  logic [XLEN-1:0] dvs_sub;
  logic [XLEN-1:0] min_val;
  logic [XLEN-1:0] one_val;
  logic            is_signed;
  logic            ovf_case;
  logic            zero_case;
  logic            neg_a;
  logic            neg_b;

  // Short-form operand extension; a full-width word form passes through
  generate
    if (WLEN < XLEN) begin : g_narrow
      assign sx_a = {{(XLEN-WLEN){dividend_i[WLEN-1]}}, dividend_i[WLEN-1:0]};
      assign sx_b = {{(XLEN-WLEN){divisor_i[WLEN-1]}},  divisor_i[WLEN-1:0]};
      assign zx_a = {{(XLEN-WLEN){1'b0}}, dividend_i[WLEN-1:0]};
      assign zx_b = {{(XLEN-WLEN){1'b0}}, divisor_i[WLEN-1:0]};
    end else begin : g_full
      assign sx_a = dividend_i;
      assign sx_b = divisor_i;
      assign zx_a = dividend_i;
      assign zx_b = divisor_i;
    end
  endgenerate

  assign min_val   = {1'b1, {(XLEN-1){1'b0}}};
  assign one_val   = {{(XLEN-1){1'b0}}, 1'b1};
  assign is_signed = ~op_i.uns;

  always_comb begin
    if (op_i.word) begin
      ext_a = op_i.uns ? zx_a : sx_a;
      ext_b = op_i.uns ? zx_b : sx_b;
    end else begin
      ext_a = dividend_i;
      ext_b = divisor_i;
    end
  end

  // Divisor substitution: overflow pair (signed full width only) or zero
  always_comb begin
    ovf_case  = is_signed & ~op_i.word & (dividend_i == min_val) & (&divisor_i);
    zero_case = (ext_b == '0);
    dvs_sub   = (ovf_case | zero_case) ? one_val : ext_b;
  end

  always_comb begin
    neg_a     = is_signed & ext_a[XLEN-1];
    neg_b     = is_signed & dvs_sub[XLEN-1];
    mag_dvd_o = neg_a ? (~ext_a + one_val) : ext_a;
    mag_dvs_o = neg_b ? (~dvs_sub + one_val) : dvs_sub;
    neg_quo_o = neg_a ^ neg_b;
    neg_rem_o = neg_a;
  end

endmodule

// File: rtl/div_restoring_core.sv
module div_restoring_core #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            step_i,
  input  logic [XLEN-1:0] dvd_i,
  input  logic [XLEN-1:0] dvs_i,
  output logic [XLEN-1:0] quo_o,
  output logic [XLEN-1:0] rem_o
);

  localparam int TW = XLEN + 2;

  logic [XLEN-1:0] quo_q, quo_d;
  logic [XLEN-1:0] rem_q, rem_d;
  logic [XLEN-1:0] dvs_q, dvs_d;
  logic [TW-1:0]   trial;
  logic            fits;
  logic            reg_en;

  // One restoring step: shift in next dividend bit, try to subtract
  always_comb begin
    trial = {1'b0, rem_q, quo_q[XLEN-1]} - {2'b00, dvs_q};
    fits  = ~trial[TW-1];
  end

  always_comb begin
    quo_d = quo_q;
    rem_d = rem_q;
    dvs_d = dvs_q;
    if (load_i) begin
      quo_d = dvd_i;
      rem_d = '0;
      dvs_d = dvs_i;
    end else if (step_i) begin
      quo_d = {quo_q[XLEN-2:0], fits};
      rem_d = fits ? trial[XLEN-1:0] : {rem_q[XLEN-2:0], quo_q[XLEN-1]};
    end
  end

  assign reg_en = load_i | step_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q <= '0;
      rem_q <= '0;
      dvs_q <= '0;
    end else if (reg_en) begin
      quo_q <= quo_d;
      rem_q <= rem_d;
      dvs_q <= dvs_d;
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;

endmodule

// File: rtl/div_result_fix.sv
module div_result_fix
  import div_iter_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  div_op_t         op_i,
  input  logic            neg_quo_i,
  input  logic            neg_rem_i,
  input  logic [XLEN-1:0] quo_i,
  input  logic [XLEN-1:0] rem_i,
  output logic [XLEN-1:0] result_o
);

  logic [XLEN-1:0] pick;
  logic            neg;
  logic [XLEN-1:0] signed_val;
  logic [XLEN-1:0] word_val;

  always_comb begin
    pick       = op_i.rem ? rem_i : quo_i;
    neg        = op_i.rem ? neg_rem_i : neg_quo_i;
    signed_val = neg ? (~pick + {{(XLEN-1){1'b0}}, 1'b1}) : pick;
  end

  generate
    if (WLEN < XLEN) begin : g_wsext
      assign word_val = {{(XLEN-WLEN){signed_val[WLEN-1]}}, signed_val[WLEN-1:0]};
    end else begin : g_wfull
      assign word_val = signed_val;
    end
  endgenerate

  assign result_o = op_i.word ? word_val : signed_val;

endmodule

// File: rtl/div_iter.sv
module div_iter
  import div_iter_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [2:0]      op_i,
  input  logic [XLEN-1:0] dividend_i,
  input  logic [XLEN-1:0] divisor_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [XLEN-1:0] result_o
);

  localparam int CNT_W = (XLEN > 1) ? $clog2(XLEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(XLEN - 1);

  div_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  div_op_t         op_in;
  div_op_t         op_q;
  logic            nq_q, nr_q;
  logic [XLEN-1:0] result_q, result_d;
  logic            done_q, done_d;

  logic [XLEN-1:0] mag_dvd, mag_dvs;
  logic            neg_quo, neg_rem;
  logic [XLEN-1:0] core_quo, core_rem;
  logic [XLEN-1:0] fixed;

  logic            accept;
  logic            step;
  logic            cnt_en;
  logic            res_en;

  assign op_in  = div_op_t'(op_i);
  assign accept = start_i & (state_q == ST_IDLE);
  assign step   = (state_q == ST_RUN);
  assign cnt_en = accept | step;
  assign res_en = (state_q == ST_FIX);

  div_operand_prep #(.XLEN(XLEN), .WLEN(WLEN)) u_prep (
    .op_i       (op_in),
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .mag_dvd_o  (mag_dvd),
    .mag_dvs_o  (mag_dvs),
    .neg_quo_o  (neg_quo),
    .neg_rem_o  (neg_rem)
  );

  div_restoring_core #(.XLEN(XLEN)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .step_i (step),
    .dvd_i  (mag_dvd),
    .dvs_i  (mag_dvs),
    .quo_o  (core_quo),
    .rem_o  (core_rem)
  );

  div_result_fix #(.XLEN(XLEN), .WLEN(WLEN)) u_fix (
    .op_i      (op_q),
    .neg_quo_i (nq_q),
    .neg_rem_i (nr_q),
    .quo_i     (core_quo),
    .rem_i     (core_rem),
    .result_o  (fixed)
  );

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    result_d = result_q;
    done_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_RUN;
          cnt_d   = '0;
        end
      end
      ST_RUN: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CNT_LAST) begin
          state_d = ST_FIX;
        end
      end
      ST_FIX: begin
        result_d = fixed;
        done_d   = 1'b1;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= '0;
      nq_q <= 1'b0;
      nr_q <= 1'b0;
    end else if (accept) begin
      op_q <= op_in;
      nq_q <= neg_quo;
      nr_q <= neg_rem;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
    end else if (res_en) begin
      result_q <= result_d;
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign result_o = result_q;

endmodule

// File: rtl/div_iter_chk.sv
module div_iter_chk #(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic [2:0]      op_i,
  input logic [XLEN-1:0] dividend_i,
  input logic [XLEN-1:0] divisor_i,
  input logic            busy_o,
  input logic            done_o,
  input logic [XLEN-1:0] result_o
);

  localparam int LW = $clog2(XLEN + 4) + 1;
  localparam logic [XLEN-1:0] MINV = {1'b1, {(XLEN-1){1'b0}}};

  logic [2:0]      cap_op;
  logic [XLEN-1:0] cap_a;
  logic [XLEN-1:0] cap_b;
  logic [LW-1:0]   lat;
  logic            cap_bzero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_op <= '0;
      cap_a  <= '0;
      cap_b  <= '0;
      lat    <= '0;
    end else if (start_i && !busy_o) begin
      cap_op <= op_i;
      cap_a  <= dividend_i;
      cap_b  <= divisor_i;
      lat    <= '0;
    end else if (busy_o) begin
      lat <= lat + 1'b1;
    end
  end

  assign cap_bzero = cap_op[2] ? (cap_b[WLEN-1:0] == '0) : (cap_b == '0);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R7
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  // R7
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  // R7
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (lat == LW'(XLEN + 1)));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));

  // R3
  min_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && cap_op == 3'b000 && cap_a == MINV && (&cap_b)) |-> (result_o == MINV));

  // R4
  zero_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && cap_op[0] && cap_bzero) |-> (result_o == '0));

  // R9
  reset_out_chk: assert property (@(posedge clk)
    !rst_n |-> (!busy_o && !done_o && result_o == '0));

endmodule

bind div_iter div_iter_chk #(.XLEN(XLEN), .WLEN(WLEN)) u_div_iter_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .op_i       (op_i),
  .dividend_i (dividend_i),
  .divisor_i  (divisor_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .result_o   (result_o)
);

// File: tb/tb_div_iter.sv
`timescale 1ns/1ps
module tb_div_iter;

  localparam int XLEN = 64;
  localparam int NV   = 21;

  logic            clk;
  logic            rst_n;
  logic            start_i;
  logic [2:0]      op_i;
  logic [XLEN-1:0] dividend_i;
  logic [XLEN-1:0] divisor_i;
  logic            busy_o;
  logic            done_o;
  logic [XLEN-1:0] result_o;

  int n_chk;
  int n_bad;
  bit finished;

  div_iter #(.XLEN(XLEN), .WLEN(32)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {req, op, dividend, divisor, expected}
  localparam logic [198:0] VEC [NV] = '{
    {4'd1, 3'b010, 64'd100, 64'd7, 64'd14},
    {4'd1, 3'b011, 64'd100, 64'd7, 64'd2},
    {4'd1, 3'b010, 64'hFFFFFFFFFFFFFFFF, 64'd2, 64'h7FFFFFFFFFFFFFFF},
    {4'd1, 3'b011, 64'hFFFFFFFFFFFFFFFF, 64'd2, 64'd1},
    {4'd2, 3'b000, 64'hFFFFFFFFFFFFFFF9, 64'd2, 64'hFFFFFFFFFFFFFFFD},
    {4'd2, 3'b001, 64'hFFFFFFFFFFFFFFF9, 64'd2, 64'hFFFFFFFFFFFFFFFF},
    {4'd2, 3'b001, 64'd7, 64'hFFFFFFFFFFFFFFFE, 64'd1},
    {4'd2, 3'b000, 64'd7, 64'hFFFFFFFFFFFFFFFE, 64'hFFFFFFFFFFFFFFFD},
    {4'd3, 3'b000, 64'h8000000000000000, 64'hFFFFFFFFFFFFFFFF, 64'h8000000000000000},
    {4'd3, 3'b001, 64'h8000000000000000, 64'hFFFFFFFFFFFFFFFF, 64'd0},
    {4'd4, 3'b010, 64'h123, 64'd0, 64'h123},
    {4'd4, 3'b001, 64'hFFFFFFFFFFFFFFFB, 64'd0, 64'd0},
    {4'd4, 3'b000, 64'hFFFFFFFFFFFFFFFB, 64'd0, 64'hFFFFFFFFFFFFFFFB},
    {4'd5, 3'b100, 64'hDEADBEEFFFFFFFF9, 64'h1234567800000002, 64'hFFFFFFFFFFFFFFFD},
    {4'd5, 3'b101, 64'hDEADBEEFFFFFFFF9, 64'h1234567800000002, 64'hFFFFFFFFFFFFFFFF},
    {4'd5, 3'b100, 64'h0000000080000000, 64'h00000000FFFFFFFF, 64'hFFFFFFFF80000000},
    {4'd6, 3'b110, 64'hFFFFFFFFFFFFFFFE, 64'd1, 64'hFFFFFFFFFFFFFFFE},
    {4'd6, 3'b110, 64'h00000000FFFFFFFE, 64'd2, 64'h000000007FFFFFFF},
    {4'd6, 3'b111, 64'h00000000FFFFFFFF, 64'h10, 64'hF},
    {4'd4, 3'b110, 64'hAAAAAAAA80000005, 64'hFFFFFFFF00000000, 64'hFFFFFFFF80000005},
    {4'd4, 3'b111, 64'hAAAAAAAA80000005, 64'hFFFFFFFF00000000, 64'd0}
  };

  function automatic string req_name(input logic [3:0] r);
    case (r)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Starts an operation at the next edge; returns result and cycles to done
  task automatic run_op(input logic [2:0] op, input logic [XLEN-1:0] a,
                        input logic [XLEN-1:0] b, output logic [XLEN-1:0] res,
                        output int lat);
    @(negedge clk);
    op_i = op; dividend_i = a; divisor_i = b; start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 1000) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    res = result_o;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [XLEN-1:0] res;
    logic [XLEN-1:0] held;
    int lat;
    int extra;
    n_chk = 0; n_bad = 0; finished = 1'b0;
    rst_n = 1'b0; start_i = 1'b0; op_i = '0; dividend_i = '0; divisor_i = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 busy", {63'd0, busy_o}, '0);
    check("R9 done", {63'd0, done_o}, '0);
    check("R9 result", result_o, '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][194:192], VEC[i][191:128], VEC[i][127:64], res, lat);
      check(req_name(VEC[i][198:195]), res, VEC[i][63:0]);
    end

    // R7: latency, busy level, done pulse width
    @(negedge clk);
    op_i = 3'b010; dividend_i = 64'd1000; divisor_i = 64'd10; start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    check("R7 busy after accept", {63'd0, busy_o}, 64'd1);
    lat = 0;
    while (!done_o && lat < 1000) begin
      @(posedge clk); lat++; @(negedge clk);
      // R8: a start while busy must be dropped
      if (lat == 10) begin
        op_i = 3'b001; dividend_i = 64'hFFFFFFFFFFFFFFF9; divisor_i = 64'd2; start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
    end
    check("R7 latency", 64'(lat), 64'(XLEN + 1));
    check("R7 busy low at done", {63'd0, busy_o}, '0);
    check("R8 result unaffected", result_o, 64'd100);
    held = result_o;
    @(negedge clk);
    check("R7 done width", {63'd0, done_o}, '0);
    extra = 0;
    for (int k = 0; k < XLEN + 8; k++) begin
      @(negedge clk);
      if (done_o || busy_o) extra++;
    end
    check("R8 no queued op", 64'(extra), '0);
    // R10: result holds, also during the next run
    check("R10 hold idle", result_o, held);
    @(negedge clk);
    op_i = 3'b000; dividend_i = 64'd50; divisor_i = 64'd5; start_i = 1'b1;
    @(posedge clk); @(negedge clk); start_i = 1'b0;
    repeat (20) @(negedge clk);
    check("R10 hold running", result_o, held);

    // R9: reset in the middle of an operation
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 mid busy", {63'd0, busy_o}, '0);
    check("R9 mid done", {63'd0, done_o}, '0);
    check("R9 mid result", result_o, '0);
    rst_n = 1'b1;
    @(negedge clk);
    run_op(3'b000, 64'd50, 64'hFFFFFFFFFFFFFFFB, res, lat);
    check("R2 after reset", res, 64'hFFFFFFFFFFFFFFF6);

    summary();
  end

endmodule